// File: doc/BRIEF.md
# End-of-Interrupt Routing Control

This block decides where an end-of-interrupt notice goes once software retires an interrupt at the local controller. It holds a spurious-vector control register whose bit 12 turns on suppression of broadcast EOIs. It also has a read-only version register. Bit 24 of the version register tells software whether the suppression bit is implemented. A build-time capability parameter decides whether that bit exists.

When software writes the local EOI register, the block looks at the trigger mode of the vector now in service. It then either queues one broadcast EOI to every I/O controller or sends nothing. An edge-triggered vector never produces a broadcast. A level-triggered vector produces one only while suppression is off. While suppression is on, software retires a level-triggered source through a separate directed-EOI port instead. That port names the vector and the one I/O controller that should receive it. Each output is a valid/ready pair, and the block holds a queued message until the receiver takes it.

Top module: `eoi_route_ctrl`

## Requirements
- R1: After reset the spurious-vector register reads 0, so suppression is off, and neither bcast_valid nor any dir_valid bit is high.
- R2: With SUPP_CAP=1 the spurious-vector register holds a vector in bits [7:0], an enable in bit 8 and the suppression enable in bit 12. Every other bit reads 0.
- R3: With SUPP_CAP=0 bit 12 always reads 0 and a written 1 is dropped. Level-triggered EOIs then keep broadcasting.
- R4: The version register (read select 1) reads VERSION_ID in bits [7:0] and SUPP_CAP in bit 24. All other bits read 0.
- R5: A write with select 2 (local EOI) while isr_level=1 and suppression is off raises bcast_valid on the following cycle, with bcast_vec equal to isr_vec.
- R6: A local EOI with isr_level=0 (edge-triggered) never raises bcast_valid, whatever bit 12 holds.
- R7: A local EOI with isr_level=1 while suppression is on raises no broadcast.
- R8: The ext_addr_mode input has no effect on any EOI decision.
- R9: A directed-EOI write while suppression is on raises exactly one dir_valid bit, the bit at index deoi_target, with dir_vec equal to deoi_vec.
- R10: A directed-EOI write while suppression is off is dropped.
- R11: While valid is high and the matching ready is low, valid stays high and the payload stays unchanged. A new request that arrives while a message is waiting on that output is dropped.
- R12: After a cycle in which valid and the matching ready are both high, valid is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 spurious-vector, 1 version (read-only), 2 local EOI |
| reg_wdata | input | 32 | Write data |
| reg_rd_sel | input | 2 | Read select: 0 spurious-vector, 1 version |
| reg_rdata | output | 32 | Read data for reg_rd_sel |
| isr_vec | input | VEC_W | Vector currently in service |
| isr_level | input | 1 | 1 when the in-service vector is level-triggered |
| ext_addr_mode | input | 1 | Addressing mode of the controller; has no effect on EOI routing |
| deoi_wr_en | input | 1 | Directed-EOI write strobe |
| deoi_vec | input | VEC_W | Vector for the directed EOI |
| deoi_target | input | IOC_W | Index of the receiving I/O controller |
| bcast_valid | output | 1 | Broadcast EOI waiting |
| bcast_ready | input | 1 | Receiver takes the broadcast |
| bcast_vec | output | VEC_W | Vector of the broadcast EOI |
| dir_valid | output | NUM_IOC | One-hot valid per I/O controller for a directed EOI |
| dir_ready | input | NUM_IOC | Per-controller ready |
| dir_vec | output | VEC_W | Vector of the directed EOI |

## Verification
The hardest case to reach from the ports is a second request that arrives while an earlier one is still waiting. Both the broadcast and the directed paths can hit it. The bench holds the matching ready low, then issues another EOI with a different vector. It checks that the first payload survives and that the second message never shows up. A second instance built without the capability gets the same stimulus. Its outputs show that setting bit 12 there changes nothing and that its directed port stays silent.

// File: rtl/eoi_pkg.sv
// Shared constants for the EOI routing block: register selects and field positions.
package eoi_pkg;
    typedef enum logic [1:0] {
        SEL_SPUR = 2'd0,
        SEL_VER  = 2'd1,
        SEL_EOI  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int SPUR_VEC_W  = 8;
    localparam int SPUR_EN_BIT = 8;
    localparam int SUPP_BIT    = 12;
    localparam int VER_CAP_BIT = 24;
endpackage

// File: rtl/eoi_cfg_regs.sv
// Spurious-vector control and version registers, plus local-EOI strobe decode.
// Assumes one access per cycle; the version register is read-only.
module eoi_cfg_regs
    import eoi_pkg::*;
#(
    parameter bit       SUPP_CAP   = 1'b1,
    parameter bit [7:0] VERSION_ID = 8'h14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wdata,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rdata,
    output logic        supp_on,
    output logic        eoi_wr
);
    logic [SPUR_VEC_W-1:0] spur_vec_q;
    logic                  spur_en_q;
    logic                  spur_wr;
    logic                  unused_wd;

    assign spur_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_SPUR);
    assign eoi_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_EOI);
    assign unused_wd = ^wdata;

    // Vector and enable fields of the spurious-vector register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spur_vec_q <= '0;
            spur_en_q  <= 1'b0;
        end else if (spur_wr) begin
            spur_vec_q <= wdata[SPUR_VEC_W-1:0];
            spur_en_q  <= wdata[SPUR_EN_BIT];
        end
    end

    // Suppression bit exists only when the capability is built in.
    generate
        if (SUPP_CAP) begin : g_supp
            logic supp_q;
            always_ff @(posedge clk) begin
                if (!rst_n)       supp_q <= 1'b0;
                else if (spur_wr) supp_q <= wdata[SUPP_BIT];
            end
            assign supp_on = supp_q;
        end else begin : g_nosupp
            assign supp_on = 1'b0;
        end
    endgenerate

    // Read mux over the two readable registers.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(rd_sel))
            SEL_SPUR: begin
                rdata[SPUR_VEC_W-1:0] = spur_vec_q;
                rdata[SPUR_EN_BIT]    = spur_en_q;
                rdata[SUPP_BIT]       = supp_on;
            end
            SEL_VER: begin
                rdata[7:0]         = VERSION_ID;
                rdata[VER_CAP_BIT] = SUPP_CAP;
            end
            default: rdata = '0;
        endcase
    end

    // R2 and R3: a write to the control register sets suppression only if it is built in.
    a_r2_supp_write: assert property (@(posedge clk) disable iff (!rst_n)
        spur_wr |=> (supp_on == (SUPP_CAP && $past(wdata[SUPP_BIT]))));
endmodule

// File: rtl/eoi_hold_slot.sv
// One-entry valid/ready holding stage. Loads only while empty; clears on handshake.
// Assumes the consumer samples dout whenever valid is high.
module eoi_hold_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout
);
    // Hold the message until it is taken; drop loads while occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (valid) begin
            if (ready) valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end
    end

    a_r11_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(dout)));
    a_r12_clear_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !valid);
endmodule

// File: rtl/eoi_route_ctrl.sv
// Routes end-of-interrupt notices: broadcast for level-triggered vectors when
// suppression is off, directed to a single I/O controller when it is on.
// Assumes isr_vec/isr_level describe the in-service vector at the EOI write.
module eoi_route_ctrl
    import eoi_pkg::*;
#(
    parameter bit       SUPP_CAP   = 1'b1,
    parameter int       VEC_W      = 8,
    parameter int       NUM_IOC    = 4,
    parameter bit [7:0] VERSION_ID = 8'h14,
    localparam int      IOC_W      = (NUM_IOC > 1) ? $clog2(NUM_IOC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_sel,
    input  logic [31:0]        reg_wdata,
    input  logic [1:0]         reg_rd_sel,
    output logic [31:0]        reg_rdata,
    input  logic [VEC_W-1:0]   isr_vec,
    input  logic               isr_level,
    input  logic               ext_addr_mode,
    input  logic               deoi_wr_en,
    input  logic [VEC_W-1:0]   deoi_vec,
    input  logic [IOC_W-1:0]   deoi_target,
    output logic               bcast_valid,
    input  logic               bcast_ready,
    output logic [VEC_W-1:0]   bcast_vec,
    output logic [NUM_IOC-1:0] dir_valid,
    input  logic [NUM_IOC-1:0] dir_ready,
    output logic [VEC_W-1:0]   dir_vec
);
    localparam int DW = IOC_W + VEC_W;

    logic             supp_on;
    logic             eoi_wr;
    logic             bcast_load;
    logic             dir_load;
    logic             dir_slot_valid;
    logic             dir_slot_ready;
    logic [DW-1:0]    dir_slot_q;
    logic [IOC_W-1:0] dir_tgt_q;
    logic             dir_any;
    logic             unused_mode;

    // Addressing mode is deliberately kept out of the decision.
    assign unused_mode = ext_addr_mode;

    eoi_cfg_regs #(
        .SUPP_CAP   (SUPP_CAP),
        .VERSION_ID (VERSION_ID)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wdata   (reg_wdata),
        .rd_sel  (reg_rd_sel),
        .rdata   (reg_rdata),
        .supp_on (supp_on),
        .eoi_wr  (eoi_wr)
    );

    // Broadcast only for level-triggered vectors with suppression off.
    assign bcast_load = eoi_wr && isr_level && !supp_on;

    eoi_hold_slot #(.W(VEC_W)) i_bcast_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bcast_load),
        .din   (isr_vec),
        .ready (bcast_ready),
        .valid (bcast_valid),
        .dout  (bcast_vec)
    );

    // Directed EOIs are taken only while suppression is active.
    assign dir_load = deoi_wr_en && supp_on;

    eoi_hold_slot #(.W(DW)) i_dir_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dir_load),
        .din   ({deoi_target, deoi_vec}),
        .ready (dir_slot_ready),
        .valid (dir_slot_valid),
        .dout  (dir_slot_q)
    );

    assign dir_tgt_q      = dir_slot_q[DW-1:VEC_W];
    assign dir_vec        = dir_slot_q[VEC_W-1:0];
    assign dir_slot_ready = dir_ready[dir_tgt_q];

    // Decode the held target into a per-controller valid.
    generate
        for (genvar k = 0; k < NUM_IOC; k++) begin : g_dir_valid
            assign dir_valid[k] = dir_slot_valid && (dir_tgt_q == IOC_W'(k));
        end
    endgenerate

    assign dir_any = |dir_valid;

    a_r5_bcast_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcast_valid) |-> $past(eoi_wr && isr_level && !supp_on));
    a_r6_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !isr_level && !bcast_valid) |=> !bcast_valid);
    a_r9_dir_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dir_valid));
    a_r10_dir_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_any) |-> $past(deoi_wr_en && supp_on));
endmodule

// File: tb/test_eoi_route_ctrl.sv
`timescale 1ns/1ps
module test_eoi_route_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_rd_sel = 2'd0;
    logic [31:0] reg_rdata, reg_rdata_n;
    logic [7:0]  isr_vec = '0;
    logic        isr_level = 1'b0;
    logic        ext_addr_mode = 1'b0;
    logic        deoi_wr_en = 1'b0;
    logic [7:0]  deoi_vec = '0;
    logic [1:0]  deoi_target = '0;
    logic        bcast_valid, bcast_valid_n;
    logic        bcast_ready = 1'b1;
    logic [7:0]  bcast_vec, bcast_vec_n;
    logic [3:0]  dir_valid, dir_valid_n;
    logic [3:0]  dir_ready = 4'hF;
    logic [7:0]  dir_vec, dir_vec_n;

    int checks = 0;
    int bad = 0;
    logic [7:0] q_b[$];
    logic [7:0] q_n[$];
    logic [9:0] q_d[$];

    always #2 clk = ~clk;

    eoi_route_ctrl #(.SUPP_CAP(1'b1)) i_eoi_route_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata),
        .isr_vec(isr_vec), .isr_level(isr_level), .ext_addr_mode(ext_addr_mode),
        .deoi_wr_en(deoi_wr_en), .deoi_vec(deoi_vec), .deoi_target(deoi_target),
        .bcast_valid(bcast_valid), .bcast_ready(bcast_ready), .bcast_vec(bcast_vec),
        .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_vec(dir_vec)
    );

    eoi_route_ctrl #(.SUPP_CAP(1'b0)) i_eoi_route_ctrl_nocap (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata_n),
        .isr_vec(isr_vec), .isr_level(isr_level), .ext_addr_mode(ext_addr_mode),
        .deoi_wr_en(deoi_wr_en), .deoi_vec(deoi_vec), .deoi_target(deoi_target),
        .bcast_valid(bcast_valid_n), .bcast_ready(bcast_ready), .bcast_vec(bcast_vec_n),
        .dir_valid(dir_valid_n), .dir_ready(dir_ready), .dir_vec(dir_vec_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wdata = data;
        tick();
        reg_wr_en = 1'b0; reg_wr_sel = 2'd3;
    endtask

    // Local EOI; push expectations for the capable and the plain instance.
    task automatic eoi(input logic [7:0] v, input logic lvl, input bit exp_c, input bit exp_n);
        isr_vec = v; isr_level = lvl;
        if (exp_c) q_b.push_back(v);
        if (exp_n) q_n.push_back(v);
        wr_reg(2'd2, 32'h0);
        tick();
    endtask

    task automatic deoi(input logic [1:0] t, input logic [7:0] v, input bit exp_c);
        deoi_target = t; deoi_vec = v;
        if (exp_c) q_d.push_back({t, v});
        deoi_wr_en = 1'b1;
        tick();
        deoi_wr_en = 1'b0;
        tick();
    endtask

    // Scoreboard monitor: pops expected items on each handshake.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bcast_valid && bcast_ready) begin
                if (q_b.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R6 R7 unexpected broadcast act=%h exp=none", bcast_vec);
                end else chk("R5 broadcast vector", {24'b0, bcast_vec}, {24'b0, q_b.pop_front()});
            end
            if (bcast_valid_n && bcast_ready) begin
                if (q_n.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R3 unexpected broadcast act=%h exp=none", bcast_vec_n);
                end else chk("R3 broadcast vector", {24'b0, bcast_vec_n}, {24'b0, q_n.pop_front()});
            end
            if (|(dir_valid & dir_ready)) begin
                if (q_d.size() == 0) begin
                    checks++; bad++;
                    $display("FAIL R10 unexpected directed act=%h exp=none", dir_valid);
                end else begin
                    logic [9:0] e;
                    e = q_d.pop_front();
                    chk("R9 directed target", {28'b0, dir_valid}, 32'(4'b0001 << e[9:8]));
                    chk("R9 directed vector", {24'b0, dir_vec}, {24'b0, e[7:0]});
                end
            end
            if (|dir_valid_n) begin
                checks++; bad++;
                $display("FAIL R10 R3 directed from plain build act=%h exp=0", dir_valid_n);
            end
        end
    end

    initial begin
        #80000;
        checks++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        reg_rd_sel = 2'd0; #0;
        chk("R1 control after reset", reg_rdata, 32'h0);
        chk("R1 bcast_valid after reset", {31'b0, bcast_valid}, 32'h0);
        chk("R1 dir_valid after reset", {28'b0, dir_valid}, 32'h0);
        rst_n = 1'b1;
        tick();
        // R4 version register
        reg_rd_sel = 2'd1; #0;
        chk("R4 version capable", reg_rdata, 32'h0100_0014);
        chk("R4 version plain", reg_rdata_n, 32'h0000_0014);
        reg_rd_sel = 2'd0;
        // R5 level EOI, suppression off
        eoi(8'h31, 1'b1, 1, 1);
        // R6 edge EOI
        eoi(8'h32, 1'b0, 0, 0);
        tick();
        chk("R6 no broadcast for edge", {31'b0, bcast_valid}, 32'h0);
        // R8 mode input set
        ext_addr_mode = 1'b1;
        eoi(8'h33, 1'b1, 1, 1);
        // R2 / R3 register write of all ones
        wr_reg(2'd0, 32'hFFFF_FFFF);
        #0;
        chk("R2 control readback", reg_rdata, 32'h0000_11FF);
        chk("R3 reserved bit readback", reg_rdata_n, 32'h0000_01FF);
        // R7 suppression on, level EOI: plain build still broadcasts (R3)
        ext_addr_mode = 1'b0;
        eoi(8'h40, 1'b1, 0, 1);
        tick();
        chk("R7 no broadcast while suppressed", {31'b0, bcast_valid}, 32'h0);
        ext_addr_mode = 1'b1;
        eoi(8'h41, 1'b1, 0, 1);
        chk("R8 suppressed with mode set", {31'b0, bcast_valid}, 32'h0);
        eoi(8'h42, 1'b0, 0, 0);
        ext_addr_mode = 1'b0;
        // R9 directed EOIs
        deoi(2'd2, 8'h44, 1);
        deoi(2'd0, 8'h45, 1);
        // R11 directed hold
        dir_ready = 4'b1011;
        deoi(2'd2, 8'h46, 1);
        tick();
        chk("R11 directed held valid", {28'b0, dir_valid}, 32'h4);
        chk("R11 directed held vector", {24'b0, dir_vec}, 32'h46);
        deoi(2'd1, 8'h47, 0);
        tick();
        chk("R11 directed payload kept", {24'b0, dir_vec}, 32'h46);
        dir_ready = 4'hF;
        tick();
        tick();
        chk("R12 directed cleared", {28'b0, dir_valid}, 32'h0);
        // R10 directed while suppression off
        wr_reg(2'd0, 32'h0000_00FF);
        #0;
        chk("R2 suppression cleared", reg_rdata, 32'h0000_00FF);
        deoi(2'd3, 8'h50, 0);
        chk("R10 directed dropped", {28'b0, dir_valid}, 32'h0);
        // R11 broadcast hold
        bcast_ready = 1'b0;
        eoi(8'h60, 1'b1, 1, 1);
        tick();
        chk("R11 broadcast held valid", {31'b0, bcast_valid}, 32'h1);
        chk("R11 broadcast held vector", {24'b0, bcast_vec}, 32'h60);
        eoi(8'h61, 1'b1, 0, 0);
        tick();
        chk("R11 broadcast payload kept", {24'b0, bcast_vec}, 32'h60);
        bcast_ready = 1'b1;
        tick();
        tick();
        chk("R12 broadcast cleared", {31'b0, bcast_valid}, 32'h0);
        repeat (4) tick();
        chk("R5 all broadcasts seen", 32'(q_b.size()), 32'h0);
        chk("R3 all plain broadcasts seen", 32'(q_n.size()), 32'h0);
        chk("R9 all directed seen", 32'(q_d.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule